// File: doc/BRIEF.md
# Logical row address allocator

This block sits at the receiving side of a remote-write path. Each incoming write names only a logical destination: a 16-bit allocation handle, a row tag and a byte offset inside the row. The block turns that triple into a physical memory address and passes the write on with its data. Software first fills a small region table through a register-write port. Each table slot holds a base address and a row size for one handle, and each slot also keeps a next-free-row pointer.

Row slots are given out lazily. The first write that carries a new (handle, tag) pair takes the next free row of its region and is recorded in a small associative table. Later pieces of the same row find that mapping and reuse the row. Each mapping counts the bytes it has received. Mappings are retired strictly oldest-first, and only once the oldest mapping's row is complete. When the table is full and its oldest row is still incomplete, a write that needs a new mapping is held at the input until that row finishes.

Top module: `row_addr_alloc`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1 while `reg_we` is 0, and every region's next-free pointer is 0.
- R2: A register write with `reg_handle` below NUM_REGIONS stores `reg_base` and `reg_row_size` for that handle and clears its next-free pointer. A register write with a larger handle changes nothing. `in_ready` is 0 in any cycle where `reg_we` is 1.
- R3: An accepted request whose (handle, tag) pair is not in the table gets the handle's next-free pointer as its local row. The pointer then advances by one, modulo 2^ROW_W.
- R4: An accepted request whose (handle, tag) pair is already in the table reuses that mapping's local row and does not move the pointer.
- R5: `out_addr` equals base + local_row × row_size + offset of the handle's region, modulo 2^ADDR_W. `out_data` equals the request's `in_data`.
- R6: Each mapping adds up the `in_len` of its accepted pieces. Only the oldest mapping can be retired, and it is retired in the cycle after its total reaches its row size. A later request with a retired tag misses and receives a fresh row.
- R7: When the table holds ENTRIES mappings and the oldest one is incomplete, `in_ready` is 0 for a request that would miss. Requests that hit are still accepted.
- R8: An accepted request appears on the output on the next clock edge, and requests leave in arrival order. While `out_valid` is 1 and `out_ready` is 0, the output holds steady and `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Region registration write strobe |
| reg_handle | input | 16 | Handle being registered |
| reg_base | input | ADDR_W | Region base address |
| reg_row_size | input | SIZE_W | Region row size in bytes |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_handle | input | 16 | Allocation handle of the request |
| in_tag | input | TAG_W | Row tag |
| in_offset | input | OFF_W | Byte offset inside the row |
| in_len | input | LEN_W | Bytes carried by this piece |
| in_data | input | DATA_W | Write payload |
| out_valid | output | 1 | Resolved write valid |
| out_ready | input | 1 | Downstream accepts resolved write |
| out_addr | output | ADDR_W | Physical write address |
| out_data | output | DATA_W | Write payload |

## Verification
The hardest state to reach from the ports is a full mapping table whose oldest row is still incomplete while a younger row has already finished. In that state the stall must persist, because a younger completion does not free a slot. The stimulus opens rows in several regions with partial pieces until the table is full, and then offers a new tag. It then completes a younger row and checks that the new tag stays blocked. Finally it completes the oldest row and checks that the new tag is accepted exactly one cycle later. A long random phase follows, with backpressure, a small tag pool and occasional re-registration, and it compares every output against a queue-based reference model on every clock.

// File: rtl/rowmap_pkg.sv
package rowmap_pkg;
   localparam int HANDLE_W = 16;
endpackage

// File: rtl/rowmap_region_table.sv
module rowmap_region_table
   import rowmap_pkg::*;
#(
   parameter int NUM_REGIONS = 4,
   parameter int ADDR_W      = 32,
   parameter int SIZE_W      = 12,
   parameter int ROW_W       = 8,
   parameter int IDX_W       = $clog2(NUM_REGIONS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_base,
   input  logic [SIZE_W-1:0] wr_size,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic              alloc,
   output logic [ADDR_W-1:0] rd_base,
   output logic [SIZE_W-1:0] rd_size,
   output logic [ROW_W-1:0]  rd_next
);
   logic [ADDR_W-1:0] base_q [NUM_REGIONS];
   logic [SIZE_W-1:0] size_q [NUM_REGIONS];
   logic [ROW_W-1:0]  next_q [NUM_REGIONS];

   assign rd_base = base_q[rd_idx];
   assign rd_size = size_q[rd_idx];
   assign rd_next = next_q[rd_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_REGIONS; i++) begin
            base_q[i] <= '0;
            size_q[i] <= '0;
            next_q[i] <= '0;
         end
      end else if (wr_en) begin
         base_q[wr_idx] <= wr_base;
         size_q[wr_idx] <= wr_size;
         next_q[wr_idx] <= '0;
      end else if (alloc) begin
         next_q[rd_idx] <= rd_next + 1'b1;
      end
   end

   // R3: a fresh allocation advances exactly the pointer of its own region
   p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      alloc && !wr_en |=> next_q[$past(rd_idx)] == ROW_W'($past(rd_next) + 1'b1));
endmodule

// File: rtl/rowmap_cam.sv
module rowmap_cam
   import rowmap_pkg::*;
#(
   parameter int ENTRIES = 4,
   parameter int TAG_W   = 8,
   parameter int ROW_W   = 8,
   parameter int SIZE_W  = 12,
   parameter int LEN_W   = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [HANDLE_W-1:0] lk_handle,
   input  logic [TAG_W-1:0]    lk_tag,
   input  logic                upd_en,
   input  logic [LEN_W-1:0]    upd_len,
   input  logic [ROW_W-1:0]    ins_row,
   input  logic [SIZE_W-1:0]   ins_size,
   output logic                hit,
   output logic [ROW_W-1:0]    hit_row,
   output logic                full,
   output logic                head_done
);
   localparam int PTR_W = $clog2(ENTRIES);
   localparam int CNT_W = SIZE_W + 1;

   logic [ENTRIES-1:0]  v_q;
   logic [HANDLE_W-1:0] h_q   [ENTRIES];
   logic [TAG_W-1:0]    t_q   [ENTRIES];
   logic [ROW_W-1:0]    row_q [ENTRIES];
   logic [CNT_W-1:0]    cnt_q [ENTRIES];
   logic [SIZE_W-1:0]   sz_q  [ENTRIES];
   logic [PTR_W-1:0]    head_q, tail_q, hit_idx;
   logic [PTR_W:0]      count_q;
   logic [ENTRIES-1:0]  match;
   logic [CNT_W:0]      sum;
   logic [CNT_W-1:0]    sat;
   logic                push, pop;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_match
      assign match[g] = v_q[g] && (h_q[g] == lk_handle) && (t_q[g] == lk_tag);
   end

   always_comb begin
      hit_row = '0;
      hit_idx = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (match[i]) begin
            hit_row = row_q[i];
            hit_idx = PTR_W'(i);
         end
      end
   end

   assign hit       = |match;
   assign full      = (count_q == (PTR_W+1)'(ENTRIES));
   assign head_done = v_q[head_q] && (cnt_q[head_q] >= CNT_W'(sz_q[head_q]));
   assign sum       = {1'b0, cnt_q[hit_idx]} + (CNT_W+1)'(upd_len);
   assign sat       = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
   assign push      = upd_en && !hit;
   assign pop       = head_done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q     <= '0;
         head_q  <= '0;
         tail_q  <= '0;
         count_q <= '0;
         for (int i = 0; i < ENTRIES; i++) begin
            h_q[i]   <= '0;
            t_q[i]   <= '0;
            row_q[i] <= '0;
            cnt_q[i] <= '0;
            sz_q[i]  <= '0;
         end
      end else begin
         if (pop) begin
            v_q[head_q] <= 1'b0;
            head_q      <= head_q + 1'b1;
         end
         if (upd_en && hit) cnt_q[hit_idx] <= sat;
         if (push) begin
            v_q[tail_q]   <= 1'b1;
            h_q[tail_q]   <= lk_handle;
            t_q[tail_q]   <= lk_tag;
            row_q[tail_q] <= ins_row;
            cnt_q[tail_q] <= CNT_W'(upd_len);
            sz_q[tail_q]  <= ins_size;
            tail_q        <= tail_q + 1'b1;
         end
         count_q <= count_q + (PTR_W+1)'(push) - (PTR_W+1)'(pop);
      end
   end

   // R4: a key is held by at most one mapping
   p_unique_key_r4: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(match));
   // R7: a new mapping is only inserted where a slot is free or being freed
   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n) push |-> (!full || pop));
   // R6: occupancy never exceeds the table depth
   p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= (PTR_W+1)'(ENTRIES));
endmodule

// File: rtl/row_addr_alloc.sv
module row_addr_alloc
   import rowmap_pkg::*;
#(
   parameter int NUM_REGIONS = 4,
   parameter int ENTRIES     = 4,
   parameter int TAG_W       = 8,
   parameter int OFF_W       = 8,
   parameter int LEN_W       = 8,
   parameter int SIZE_W      = 12,
   parameter int ROW_W       = 8,
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_we,
   input  logic [HANDLE_W-1:0] reg_handle,
   input  logic [ADDR_W-1:0]   reg_base,
   input  logic [SIZE_W-1:0]   reg_row_size,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [HANDLE_W-1:0] in_handle,
   input  logic [TAG_W-1:0]    in_tag,
   input  logic [OFF_W-1:0]    in_offset,
   input  logic [LEN_W-1:0]    in_len,
   input  logic [DATA_W-1:0]   in_data,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [ADDR_W-1:0]   out_addr,
   output logic [DATA_W-1:0]   out_data
);
   localparam int IDX_W = $clog2(NUM_REGIONS);

   if (NUM_REGIONS < 2 || (1 << IDX_W) != NUM_REGIONS)
      $error("NUM_REGIONS must be a power of two, at least 2");
   if (ENTRIES < 2 || (1 << $clog2(ENTRIES)) != ENTRIES)
      $error("ENTRIES must be a power of two, at least 2");
   if (LEN_W > SIZE_W + 1) $error("LEN_W must not exceed SIZE_W + 1");
   if (IDX_W > HANDLE_W)   $error("NUM_REGIONS exceeds the handle space");

   logic [ADDR_W-1:0] rd_base, addr_next;
   logic [SIZE_W-1:0] rd_size;
   logic [ROW_W-1:0]  rd_next, hit_row, row_sel;
   logic              hit, full, head_done, miss_blocked, fire, wr_ok;

   assign wr_ok = reg_we && (reg_handle < HANDLE_W'(NUM_REGIONS));

   rowmap_region_table #(
      .NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .ROW_W(ROW_W), .IDX_W(IDX_W)
   ) u_regions (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_ok), .wr_idx(reg_handle[IDX_W-1:0]), .wr_base(reg_base), .wr_size(reg_row_size),
      .rd_idx(in_handle[IDX_W-1:0]), .alloc(fire && !hit),
      .rd_base(rd_base), .rd_size(rd_size), .rd_next(rd_next)
   );

   rowmap_cam #(
      .ENTRIES(ENTRIES), .TAG_W(TAG_W), .ROW_W(ROW_W), .SIZE_W(SIZE_W), .LEN_W(LEN_W)
   ) u_cam (
      .clk(clk), .rst_n(rst_n),
      .lk_handle(in_handle), .lk_tag(in_tag),
      .upd_en(fire), .upd_len(in_len), .ins_row(rd_next), .ins_size(rd_size),
      .hit(hit), .hit_row(hit_row), .full(full), .head_done(head_done)
   );

   assign miss_blocked = !hit && full && !head_done;
   assign in_ready     = !reg_we && (!out_valid || out_ready) && !miss_blocked;
   assign fire         = in_valid && in_ready;
   assign row_sel      = hit ? hit_row : rd_next;
   assign addr_next    = rd_base + ADDR_W'(row_sel) * ADDR_W'(rd_size) + ADDR_W'(in_offset);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_addr  <= '0;
         out_data  <= '0;
      end else if (fire) begin
         out_valid <= 1'b1;
         out_addr  <= addr_next;
         out_data  <= in_data;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   // R8: a stalled output holds its contents
   p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_data));
   // R8: an accepted request is presented one edge later
   p_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid);
   // R2: registration and request acceptance never share a cycle
   p_reg_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> !in_ready);
endmodule

// File: tb/row_addr_alloc_test.sv
`timescale 1ns/1ps
module row_addr_alloc_test;
   localparam int NR = 4;
   localparam int NE = 4;

   logic        clk = 0, rst_n = 0;
   logic        reg_we = 0;
   logic [15:0] reg_handle = 0;
   logic [31:0] reg_base = 0;
   logic [11:0] reg_row_size = 0;
   logic        in_valid = 0, in_ready;
   logic [15:0] in_handle = 0;
   logic [7:0]  in_tag = 0, in_offset = 0, in_len = 0;
   logic [31:0] in_data = 0;
   logic        out_valid, out_ready = 1;
   logic [31:0] out_addr, out_data;

   row_addr_alloc uut (.*);

   always #10 clk = ~clk;

   int checks = 0, fails = 0;
   bit done = 0, fired = 0;

   longint m_base [NR];
   int     m_size [NR];
   int     m_next [NR];
   int q_h[$], q_t[$], q_row[$], q_cnt[$], q_sz[$];
   longint e_addr[$];
   longint e_data[$];

   task automatic chk(bit ok, string lbl, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL [%s] %s actual=%0h expected=%0h", lbl, what, act, exp);
      end
   endtask

   task automatic step(string lbl);
      int hi, idx, row;
      bit hit, full, hd, er, ov;
      #2;
      hi = -1;
      for (int i = 0; i < q_h.size(); i++)
         if (q_h[i] == int'(in_handle) && q_t[i] == int'(in_tag)) hi = i;
      hit  = (hi >= 0);
      full = (q_h.size() == NE);
      hd   = (q_h.size() > 0) && (q_cnt[0] >= q_sz[0]);
      ov   = (e_addr.size() > 0);
      er   = !reg_we && (!ov || out_ready) && !(!hit && full && !hd);
      chk(in_ready === er, lbl, "in_ready", longint'(in_ready), longint'(er));
      chk(out_valid === ov, lbl, "out_valid", longint'(out_valid), longint'(ov));
      if (ov) begin
         chk(out_addr === e_addr[0][31:0], lbl, "out_addr", longint'(out_addr), e_addr[0]);
         chk(out_data === e_data[0][31:0], lbl, "out_data", longint'(out_data), e_data[0]);
      end
      fired = in_valid && er;
      if (ov && out_ready) begin
         void'(e_addr.pop_front());
         void'(e_data.pop_front());
      end
      if (reg_we && reg_handle < NR) begin
         idx = int'(reg_handle);
         m_base[idx] = longint'(reg_base);
         m_size[idx] = int'(reg_row_size);
         m_next[idx] = 0;
      end
      if (fired) begin
         idx = int'(in_handle) % NR;
         if (hit) begin
            row = q_row[hi];
            q_cnt[hi] += int'(in_len);
         end else begin
            row = m_next[idx];
            m_next[idx] = (m_next[idx] + 1) % 256;
            q_h.push_back(int'(in_handle)); q_t.push_back(int'(in_tag));
            q_row.push_back(row); q_cnt.push_back(int'(in_len)); q_sz.push_back(m_size[idx]);
         end
         e_addr.push_back((m_base[idx] + longint'(row) * m_size[idx] + longint'(in_offset)) & 64'hffffffff);
         e_data.push_back(longint'(in_data));
      end
      if (hd) begin
         void'(q_h.pop_front()); void'(q_t.pop_front()); void'(q_row.pop_front());
         void'(q_cnt.pop_front()); void'(q_sz.pop_front());
      end
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic reg_write(string lbl, int h, int base, int size);
      reg_we = 1; reg_handle = 16'(h); reg_base = 32'(base); reg_row_size = 12'(size);
      step(lbl);
      reg_we = 0;
   endtask

   task automatic send(string lbl, int h, int t, int off, int len);
      in_valid = 1; in_handle = 16'(h); in_tag = 8'(t); in_offset = 8'(off); in_len = 8'(len);
      in_data = $urandom;
      for (int k = 0; k < 50; k++) begin
         step(lbl);
         if (fired) break;
      end
      in_valid = 0;
   endtask

   task automatic offer(string lbl, int h, int t, int len, int n);
      in_valid = 1; in_handle = 16'(h); in_tag = 8'(t); in_offset = 0; in_len = 8'(len);
      for (int k = 0; k < n; k++) step(lbl);
      in_valid = 0;
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL [watchdog] run did not finish actual=0 expected=1");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NR; i++) begin m_base[i] = 0; m_size[i] = 0; m_next[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: idle state straight after reset
      step("R1 reset");
      chk(in_ready === 1'b1, "R1 reset", "in_ready", longint'(in_ready), 1);
      chk(out_valid === 1'b0, "R1 reset", "out_valid", longint'(out_valid), 0);

      // R2: registration, ready held low, out-of-range handle ignored
      reg_write("R2 register", 0, 32'h1000, 256);
      reg_write("R2 register", 1, 32'h8000, 64);
      reg_write("R2 register", 2, 32'h20000, 128);
      reg_write("R2 register", 3, 32'h40000, 100);
      reg_write("R2 ignored handle", 16'h0101, 32'hdead0000, 8);
      send("R2 ignored handle", 1, 40, 4, 64);

      // R3 R5: lazy allocation in order of first use
      send("R3 R5 new rows", 0, 7, 0, 128);
      send("R3 R5 new rows", 0, 9, 0, 128);
      // R4: second piece of an open row reuses it
      send("R4 hit", 0, 7, 128, 128);
      // R6: completed oldest row retires; same tag then gets a fresh row
      step("R6 retire");
      send("R6 fresh row", 0, 7, 0, 16);

      // R7: fill table with incomplete rows, then offer a new tag
      send("R7 fill", 2, 1, 0, 10);
      send("R7 fill", 3, 2, 0, 10);
      offer("R7 blocked miss", 1, 3, 8, 3);
      send("R7 younger completes", 3, 2, 10, 90);
      offer("R7 still blocked", 1, 3, 8, 2);
      send("R7 head completes", 0, 9, 128, 128);
      send("R7 miss admitted", 1, 3, 0, 8);

      // R8: backpressure holds output and input
      out_ready = 0;
      offer("R8 backpressure", 2, 1, 4, 4);
      out_ready = 1;
      step("R8 drain");
      step("R8 drain");

      // R5 R8 random traffic against the model
      for (int c = 0; c < 4000; c++) begin
         int h, t, len, hi;
         bit full, hd;
         reg_we = 0; in_valid = 0;
         out_ready = ($urandom_range(3) != 0);
         if ($urandom_range(199) == 0) begin
            reg_we = 1; reg_handle = 16'($urandom_range(NR-1));
            reg_base = $urandom; reg_row_size = 12'($urandom_range(255, 32));
         end else if ($urandom_range(2) != 0) begin
            h = $urandom_range(NR-1); t = $urandom_range(5); len = $urandom_range(64, 1);
            hi = -1;
            for (int i = 0; i < q_h.size(); i++) if (q_h[i] == h && q_t[i] == t) hi = i;
            full = (q_h.size() == NE);
            hd   = (q_h.size() > 0) && (q_cnt[0] >= q_sz[0]);
            if (hi < 0 && full && !hd) begin
               h = q_h[0]; t = q_t[0];
               len = q_sz[0] - q_cnt[0];
               if (len > 255) len = 255;
               if (len < 1) len = 1;
            end
            in_valid = 1; in_handle = 16'(h); in_tag = 8'(t); in_len = 8'(len);
            in_offset = 8'($urandom); in_data = $urandom;
         end
         step("R5 R8 random");
      end
      reg_we = 0; in_valid = 0; out_ready = 1;
      step("R8 final drain");
      step("R8 final drain");

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule